// File: doc/BRIEF.md
# SRAM sleep handshake sequencer

This block wakes and sleeps one SRAM bank that sits inside a switchable power domain. A wake command drives a group of sleep-request lines to their active level, then waits for the bank's acknowledge lines to answer. When isolation control is built in, the block then opens the isolation controls one at a time. A sleep command runs the same steps in reverse order. Each command ends with a one-cycle `done` pulse. If the acknowledge never arrives, it ends with a one-cycle `timeout` pulse instead.

The acknowledge lines come from another timing domain, so they pass through a two-flop synchroniser. They are sampled once per poll interval. The poll interval and the isolation gap are built from a cycles-per-microsecond parameter. The give-up limit is a count of failed samples. A parameter reverses the polarity of the request lines, and the level the acknowledges must reach follows that polarity. A second parameter removes the isolation steps altogether.

Top module: `sram_pdn_seq`

## Requirements
- R1: After reset, with isolation present, the request lines are at the asleep level (all ones with normal polarity, all zeros with inverted polarity), `clk_iso` is 1, `iso_int_n` is 0, and `busy`, `done` and `timeout` are 0.
- R2: With normal polarity, a wake command accepted in idle drives every request line to 0 in the cycle after acceptance. The sequence waits until every synchronised acknowledge bit is 0. If wake and sleep are raised together, wake is taken.
- R3: With inverted polarity, a wake command drives every request line to 1 and waits until every acknowledge bit is 1.
- R4: A sleep command drives the request lines to the asleep level and waits for the acknowledges to reach that same level: all ones with normal polarity, all zeros with inverted polarity.
- R5: When isolation is present, a wake command that has matched its acknowledges raises `iso_int_n`. Exactly CYC_PER_US cycles later it lowers `clk_iso` and pulses `done` in that same cycle.
- R6: When isolation is present, a sleep command raises `clk_iso` in the cycle after acceptance and lowers `iso_int_n` CYC_PER_US cycles later. The request lines change one cycle after that.
- R7: Without isolation, `clk_iso` stays 0 and `iso_int_n` stays 1 at all times.
- R8: The acknowledges are compared once every CYC_PER_US*POLL_US cycles, counted from the cycle the request lines change. A compare in which only some bits match does not end the wait. Without isolation, `done` is visible k*CYC_PER_US*POLL_US cycles after the request change, where k is the first matching sample.
- R9: After MAX_POLLS failed samples, `timeout` pulses and `done` does not. All other outputs keep their last values, and the block returns to idle and accepts the next command.
- R10: Any command raised while `busy` is 1 is ignored. The request lines do not change except at the defined steps of the running sequence.
- R11: `done` and `timeout` are each high for exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_cmd | input | 1 | Start a wake sequence (sampled in idle) |
| sleep_cmd | input | 1 | Start a sleep sequence (sampled in idle) |
| sleep_ack | input | BANK_W | Acknowledge lines from the bank, asynchronous |
| sleep_req | output | BANK_W | Request lines to the bank |
| clk_iso | output | 1 | Clock isolation, high isolates |
| iso_int_n | output | 1 | Internal isolation, low isolates |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| timeout | output | 1 | One-cycle pulse: acknowledge never matched |

## Verification
Two situations are hard to reach from the ports: a wait that runs out of samples, and an acknowledge that is only partly right when a sample is taken. The bench sets the poll interval and the sample limit to small values, so the timeout comes after a few hundred cycles instead of a second. It holds the acknowledge lines still to force the timeout. To get a partial match, it drives part of the acknowledge pattern before the first sample point and the rest before the second. It then measures the exact cycle of each output change, counted from command acceptance.

// File: rtl/sram_pdn_seq.sv
module sram_pdn_seq #(
  parameter int BANK_W     = 4,
  parameter bit INV_POL    = 1'b0,
  parameter bit HAS_ISO    = 1'b1,
  parameter int CYC_PER_US = 250,
  parameter int POLL_US    = 10,
  parameter int MAX_POLLS  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_cmd,
  input  logic              sleep_cmd,
  input  logic [BANK_W-1:0] sleep_ack,
  output logic [BANK_W-1:0] sleep_req,
  output logic              clk_iso,
  output logic              iso_int_n,
  output logic              busy,
  output logic              done,
  output logic              timeout
);

  localparam int POLL_CYC = CYC_PER_US * POLL_US;
  localparam int TW = $clog2(POLL_CYC + 1);
  localparam int GW = $clog2(CYC_PER_US + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [BANK_W-1:0] REQ_OFF = INV_POL ? '0 : '1;
  localparam logic [BANK_W-1:0] REQ_ON  = ~REQ_OFF;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_REQ, S_POLL} st_t;

  st_t               state;
  logic              going_on;
  logic [BANK_W-1:0] ack_m, ack_s;
  logic [TW-1:0]     tick;
  logic [GW-1:0]     gap;
  logic [PW-1:0]     polls;
  logic              clk_iso_q, iso_n_q;

  wire tick_end = (tick == TW'(POLL_CYC - 1));
  wire gap_end  = (gap == GW'(CYC_PER_US - 1));
  wire ack_ok   = (ack_s == sleep_req);
  wire last_try = (polls == PW'(MAX_POLLS - 1));

  assign busy      = (state != S_IDLE);
  assign clk_iso   = HAS_ISO ? clk_iso_q : 1'b0;
  assign iso_int_n = HAS_ISO ? iso_n_q : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= '0;
      ack_s <= '0;
    end else begin
      ack_m <= sleep_ack;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      going_on  <= 1'b0;
      sleep_req <= REQ_OFF;
      clk_iso_q <= 1'b1;
      iso_n_q   <= 1'b0;
      tick      <= '0;
      gap       <= '0;
      polls     <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        S_IDLE: begin
          tick  <= '0;
          gap   <= '0;
          polls <= '0;
          if (wake_cmd) begin
            going_on  <= 1'b1;
            sleep_req <= REQ_ON;
            state     <= S_POLL;
          end else if (sleep_cmd) begin
            going_on <= 1'b0;
            if (HAS_ISO) begin
              clk_iso_q <= 1'b1;
              state     <= S_GAP;
            end else begin
              sleep_req <= REQ_OFF;
              state     <= S_POLL;
            end
          end
        end
        S_GAP: begin
          if (gap_end) begin
            gap <= '0;
            if (going_on) begin
              clk_iso_q <= 1'b0;
              done      <= 1'b1;
              state     <= S_IDLE;
            end else begin
              iso_n_q <= 1'b0;
              state   <= S_REQ;
            end
          end else begin
            gap <= gap + 1'b1;
          end
        end
        S_REQ: begin
          sleep_req <= REQ_OFF;
          state     <= S_POLL;
        end
        default: begin
          if (tick_end) begin
            tick <= '0;
            if (ack_ok) begin
              if (going_on && HAS_ISO) begin
                iso_n_q <= 1'b1;
                state   <= S_GAP;
              end else begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end else if (last_try) begin
              timeout <= 1'b1;
              state   <= S_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_to_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  p_done_to_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_REQ) |=> $stable(sleep_req));

  generate
    if (HAS_ISO) begin : g_iso_chk
      p_iso_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_iso) |-> (iso_int_n && $past(iso_int_n)));
      p_iso_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_int_n) |-> (clk_iso && $past(clk_iso)));
      p_req_after_iso_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sleep_req) && sleep_req == REQ_OFF) |-> !iso_int_n);
    end
  endgenerate

endmodule

// File: tb/tb_sram_pdn_seq.sv
module tb_sram_pdn_seq;
  localparam int CYC = 4;
  localparam int PU  = 10;
  localparam int MP  = 5;
  localparam int P   = CYC * PU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       wa = 0, sa = 0, wb = 0, sb = 0;
  logic [3:0] ack_a = 4'hF, ack_b = 4'h0;
  logic [3:0] req_a, req_b;
  logic       cki_a, cki_b, isn_a, isn_b, bsy_a, bsy_b, dn_a, dn_b, to_a, to_b;

  sram_pdn_seq #(.BANK_W(4), .INV_POL(1'b0), .HAS_ISO(1'b1), .CYC_PER_US(CYC),
                 .POLL_US(PU), .MAX_POLLS(MP)) dut (
    .clk(clk), .rst_n(rst_n), .wake_cmd(wa), .sleep_cmd(sa), .sleep_ack(ack_a),
    .sleep_req(req_a), .clk_iso(cki_a), .iso_int_n(isn_a), .busy(bsy_a),
    .done(dn_a), .timeout(to_a));

  sram_pdn_seq #(.BANK_W(4), .INV_POL(1'b1), .HAS_ISO(1'b0), .CYC_PER_US(CYC),
                 .POLL_US(PU), .MAX_POLLS(MP)) dut_inv (
    .clk(clk), .rst_n(rst_n), .wake_cmd(wb), .sleep_cmd(sb), .sleep_ack(ack_b),
    .sleep_req(req_b), .clk_iso(cki_b), .iso_int_n(isn_b), .busy(bsy_b),
    .done(dn_b), .timeout(to_b));

  logic sel = 1'b0;
  wire [3:0] o_req = sel ? req_b : req_a;
  wire o_cki = sel ? cki_b : cki_a;
  wire o_isn = sel ? isn_b : isn_a;
  wire o_bsy = sel ? bsy_b : bsy_a;
  wire o_dn  = sel ? dn_b : dn_a;
  wire o_to  = sel ? to_b : to_a;

  int total = 0, fails = 0;
  int t_iso_on, t_iso_off, t_ck_on, t_ck_off, t_done, t_to, t_req, n_done, n_to, n_req;
  logic [3:0] req_before;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_ack(input logic [3:0] v);
    if (sel) ack_b = v; else ack_a = v;
  endtask

  task automatic set_cmd(input bit w, input bit s);
    if (sel) begin wb = w; sb = s; end else begin wa = w; sa = s; end
  endtask

  task automatic issue(input bit w, input bit s);
    req_before = o_req;
    @(negedge clk);
    set_cmd(w, s);
    @(negedge clk);
    set_cmd(0, 0);
  endtask

  task automatic trace(input int cycles, input int a1_at, input logic [3:0] a1_v,
                       input int a2_at, input logic [3:0] a2_v, input int c_at);
    logic [3:0] prev;
    prev = req_before;
    t_iso_on = -1; t_iso_off = -1; t_ck_on = -1; t_ck_off = -1;
    t_done = -1; t_to = -1; t_req = -1; n_done = 0; n_to = 0; n_req = 0;
    for (int n = 0; n < cycles; n++) begin
      if (o_isn && t_iso_on < 0) t_iso_on = n;
      if (!o_isn && t_iso_off < 0) t_iso_off = n;
      if (o_cki && t_ck_on < 0) t_ck_on = n;
      if (!o_cki && t_ck_off < 0) t_ck_off = n;
      if (o_req != prev) begin
        n_req++;
        if (t_req < 0) t_req = n;
        prev = o_req;
      end
      if (o_dn) begin n_done++; if (t_done < 0) t_done = n; end
      if (o_to) begin n_to++; if (t_to < 0) t_to = n; end
      if (n == a1_at) set_ack(a1_v);
      if (n == a2_at) set_ack(a2_v);
      if (n == c_at) set_cmd(1, 0);
      if (n == c_at + 1) set_cmd(0, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 req after reset", int'(req_a), 15);
    chk("R1 clk_iso after reset", int'(cki_a), 1);
    chk("R1 iso_int_n after reset", int'(isn_a), 0);
    chk("R1 busy/done/timeout after reset", int'({bsy_a, dn_a, to_a}), 0);
    chk("R1 inverted req after reset", int'(req_b), 0);
    chk("R7 clk_iso without isolation", int'(cki_b), 0);
    chk("R7 iso_int_n without isolation", int'(isn_b), 1);
  endtask

  task automatic t_wake_iso;
    sel = 0;
    issue(1, 1);
    chk("R2 wake wins, req cleared", int'(req_a), 0);
    chk("R10 busy while running", int'(bsy_a), 1);
    trace(80, 0, 4'h0, -1, 4'h0, -1);
    chk("R8 first sample releases internal iso", t_iso_on, P);
    chk("R5 clock iso release gap", t_ck_off - t_iso_on, CYC);
    chk("R5 done with clock iso release", t_done, P + CYC);
    chk("R11 single done pulse", n_done, 1);
    chk("R2 busy cleared after wake", int'(bsy_a), 0);
  endtask

  task automatic t_sleep_iso_ignore;
    sel = 0;
    issue(0, 1);
    trace(120, 5, 4'hF, -1, 4'h0, 20);
    chk("R6 clock iso raised first", t_ck_on, 0);
    chk("R6 internal iso after gap", t_iso_off, CYC);
    chk("R6 req change after isolation", t_req, CYC + 1);
    chk("R4 sleep req level", int'(req_a), 15);
    chk("R4 done after ack high", t_done, CYC + 1 + P);
    chk("R10 wake during busy ignored, one req change", n_req, 1);
    chk("R10 only one done", n_done, 1);
    chk("R10 iso still closed", int'({cki_a, isn_a}), 2);
  endtask

  task automatic t_timeout_and_recover;
    sel = 0;
    issue(1, 0);
    trace(MP * P + 60, -1, 4'h0, -1, 4'h0, -1);
    chk("R9 timeout cycle", t_to, MP * P);
    chk("R11 single timeout pulse", n_to, 1);
    chk("R9 no done on timeout", n_done, 0);
    chk("R9 req held", int'(req_a), 0);
    chk("R9 iso held", int'({cki_a, isn_a}), 2);
    chk("R9 idle after timeout", int'(bsy_a), 0);
    ack_a = 4'h0;
    repeat (4) @(negedge clk);
    issue(1, 0);
    trace(80, -1, 4'h0, -1, 4'h0, -1);
    chk("R9 recovery wake completes", t_done, P + CYC);
    chk("R9 recovery iso opened", int'({cki_a, isn_a}), 1);
  endtask

  task automatic t_inverted;
    sel = 1;
    issue(1, 0);
    chk("R3 inverted wake sets req", int'(req_b), 15);
    trace(120, 0, 4'h7, 50, 4'hF, -1);
    chk("R8 partial match not accepted", t_done, 2 * P);
    chk("R7 no clock iso activity", t_ck_on, -1);
    chk("R7 no internal iso activity", t_iso_off, -1);
    issue(0, 1);
    chk("R4 inverted sleep clears req", int'(req_b), 0);
    trace(80, 0, 4'h0, -1, 4'h0, -1);
    chk("R4 R8 inverted sleep done at first sample", t_done, P);
    chk("R11 inverted single done", n_done, 1);
    sel = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake_iso();
    t_sleep_iso_ignore();
    t_timeout_and_recover();
    t_inverted();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule